// File: doc/BRIEF.md
# Wiper and Configuration Persistence Controller

This block keeps the working copies of two attenuator wiper settings and a three-bit configuration word. It decides when these three values are copied into a small three-byte nonvolatile store. The bus interface in front of it delivers register write strobes with a two-bit target select and a STOP indication. The wiper update logic reports, through a pending flag, whether it is still waiting for a zero-crossing.

At power-up the controller reads the store before it accepts any access. It restores the configuration from the store. In nonvolatile mode it also restores both wipers. In volatile mode it parks both wipers at the mute code of the selected attenuation option.

A commit is held back until the bus signals STOP. If zero-cross gating is enabled, it is held back further until the pending wiper update has finished. Each commit rewrites all three bytes. While the controller is loading, waiting to commit or programming, it reports busy, and the bus interface uses that flag to refuse its address. The store's programming time is a parameter counted in clock cycles.

Top module: `nvsettings_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `nv_wr_req` is 0. On the first clock edge after reset is released, the store is read and `busy` falls. With the factory image, `cfg_bits` reads 3'b111, which corresponds to stored byte 87h.
- R2: The configuration fields are: bit 2 is the storage mode (1 = volatile), bit 1 enables zero-cross gating, and bit 0 selects the attenuation option. When the loaded configuration has bit 2 = 1, both wipers come up at the mute code of the option: 33 when bit 0 = 1, and 63 when bit 0 = 0.
- R3: In volatile mode, a transaction that writes only wipers is not committed. Its STOP raises neither `nv_wr_req` nor `busy`, and the new wiper value appears on the output at once. A STOP with no preceding write also raises no request.
- R4: When a commit is due at STOP and both bit 1 and `zc_pending` are 1, `busy` rises but no request is issued while `zc_pending` stays 1. The request pulse follows on the first clock edge that sees `zc_pending` at 0.
- R5: `nv_wr_req` is a single-cycle pulse, issued once per commit. From the edge that issues it, `busy` stays high for exactly `PROG_CYCLES`+2 clock cycles.
- R6: A commit writes all three bytes. They carry the working values of both wipers and the configuration at the time of the request, and are read back by the next power-up.
- R7: Write strobes and STOP indications that arrive while `busy` is 1 have no effect on any register and raise no request.
- R8: `wr_sel` encodes the target: 2'b00 is wiper 0, 2'b01 is wiper 1, 2'b10 is the configuration (only `wr_data[2:0]` is used). The code 2'b11 changes nothing, and a transaction containing only such writes commits nothing.
- R9: A transaction that writes the configuration is committed at STOP whatever the storage mode. Wiper writes are committed only when bit 2 is 0.
- R10: When the loaded configuration has bit 2 = 0, power-up restores both wipers from the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| wr_en | input | 1 | Register write strobe from the bus interface |
| wr_sel | input | 2 | Target select: 00 wiper 0, 01 wiper 1, 10 configuration, 11 reserved |
| wr_data | input | 6 | Write data (wiper code, or configuration in bits 2:0) |
| stop_seen | input | 1 | One-cycle pulse when the bus signals STOP |
| zc_pending | input | 1 | Wiper update still waiting for a zero-crossing |
| busy | output | 1 | Loading, waiting to commit, or programming; address to be refused |
| nv_wr_req | output | 1 | One-cycle request that starts a three-byte store write |
| wiper0 | output | 6 | Working setting of wiper 0 |
| wiper1 | output | 6 | Working setting of wiper 1 |
| cfg_bits | output | 3 | Working configuration: bit 2 mode, bit 1 zero-cross gate, bit 0 option |

## Verification
A lost or stale commit-due flag does not show up when it occurs. It shows up only after the next power cycle, when the wipers or the configuration come back with old values. The bench therefore follows every commit with a reset and a readback. A sequencer stuck in its wait or programming state shows at once as a `busy` that outlasts `PROG_CYCLES`+2 cycles, so the exact busy length is measured. A write leaking through while busy changes a wiper output within one cycle; the checker catches it as it happens and the bench catches it after `busy` falls.

// File: rtl/nvp_pkg.sv
// Shared constants, state encoding and helpers for the persistence controller.
// Assumes wiper codes are six bits wide and the configuration word is three bits.
package nvp_pkg;
    localparam int WIPER_W = 6;
    localparam int CFG_W   = 3;
    localparam int NBYTES  = 3;
    localparam int IMAGE_W = NBYTES * 8;

    // Configuration field positions
    localparam int CFG_VOL = 2;
    localparam int CFG_ZC  = 1;
    localparam int CFG_OPT = 0;

    // Write target select codes
    localparam logic [1:0] SEL_W0  = 2'b00;
    localparam logic [1:0] SEL_W1  = 2'b01;
    localparam logic [1:0] SEL_CFG = 2'b10;

    localparam logic [CFG_W-1:0] FACTORY_CFG = 3'b111;

    // Store byte layout: byte0 = {00, wiper0}, byte1 = {01, wiper1}, byte2 = {10000, cfg}
    localparam logic [IMAGE_W-1:0] FACTORY_IMAGE = 24'h87_61_21;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_IDLE,
        ST_WAIT_ZC,
        ST_PROG
    } nvp_state_e;

    // Mute code of an attenuation option
    function automatic logic [WIPER_W-1:0] mute_code(input logic opt);
        return opt ? 6'd33 : 6'd63;
    endfunction
endpackage

// File: rtl/nvp_store.sv
// Behavioural three-byte nonvolatile store with a fixed programming delay.
// The cells are not cleared by rst_n and keep their contents across power cycles.
// The write data is sampled when a request is accepted and lands in the cells
// PROG_CYCLES cycles later. Requests made while programming are dropped.
module nvp_store #(
    parameter int                             PROG_CYCLES = 50000,
    parameter int                             NBYTES      = 3,
    parameter logic [NBYTES*8-1:0]            INIT_IMAGE  = 24'h87_61_21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [NBYTES*8-1:0]   wdata,
    output logic [NBYTES*8-1:0]   rdata,
    output logic                  prog_busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [NBYTES*8-1:0] shadow_q;
    logic                accept;
    logic                finish;

    assign accept    = req && !prog_busy;
    assign finish    = prog_busy && (cnt_q == '0);

    // Programming timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_busy <= 1'b0;
            cnt_q     <= '0;
        end else if (accept) begin
            prog_busy <= 1'b1;
            cnt_q     <= CNT_W'(PROG_CYCLES - 1);
        end else if (finish) begin
            prog_busy <= 1'b0;
        end else if (prog_busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Snapshot of the image to be programmed
    always_ff @(posedge clk) begin
        if (accept) shadow_q <= wdata;
    end

    // One persistent cell per byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_cell
        logic [7:0] cell_q = INIT_IMAGE[b*8 +: 8];
        // Commit this byte when programming completes
        always_ff @(posedge clk) begin
            if (finish) cell_q <= shadow_q[b*8 +: 8];
        end
        assign rdata[b*8 +: 8] = cell_q;
    end
endmodule

// File: rtl/nvp_regs.sv
// Working registers: two wipers and the configuration, with commit-due flags.
// At load the stored image is checked for its fixed tag bits. A bad image
// falls back to the factory configuration. Volatile mode parks both wipers at mute.
module nvp_regs
    import nvp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [IMAGE_W-1:0]   image,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [WIPER_W-1:0]   wr_data,
    input  logic                 clr_dirty,
    output logic [WIPER_W-1:0]   wiper0,
    output logic [WIPER_W-1:0]   wiper1,
    output logic [CFG_W-1:0]     cfg,
    output logic                 cfg_dirty,
    output logic                 wip_dirty
);
    logic               image_ok;
    logic [CFG_W-1:0]   ld_cfg;
    logic               park;
    logic [WIPER_W-1:0] ld_w0;
    logic [WIPER_W-1:0] ld_w1;

    // Decode the stored image into load values
    always_comb begin
        image_ok = (image[7:6] == 2'b00) && (image[15:14] == 2'b01)
                && (image[23:19] == 5'b10000);
        ld_cfg   = image_ok ? image[16 +: CFG_W] : FACTORY_CFG;
        park     = ld_cfg[CFG_VOL] || !image_ok;
        ld_w0    = park ? mute_code(ld_cfg[CFG_OPT]) : image[0 +: WIPER_W];
        ld_w1    = park ? mute_code(ld_cfg[CFG_OPT]) : image[8 +: WIPER_W];
    end

    // Working register file: load at power-up, otherwise accept strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper0 <= '0;
            wiper1 <= '0;
            cfg    <= '0;
        end else if (load_en) begin
            wiper0 <= ld_w0;
            wiper1 <= ld_w1;
            cfg    <= ld_cfg;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_W0:  wiper0 <= wr_data;
                SEL_W1:  wiper1 <= wr_data;
                SEL_CFG: cfg    <= wr_data[CFG_W-1:0];
                default: ;
            endcase
        end
    end

    // Commit-due flags: cleared at STOP, set by a write to the matching target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dirty <= 1'b0;
            wip_dirty <= 1'b0;
        end else begin
            if (clr_dirty) begin
                cfg_dirty <= 1'b0;
                wip_dirty <= 1'b0;
            end
            if (wr_en && !load_en) begin
                if (wr_sel == SEL_CFG) cfg_dirty <= 1'b1;
                if (wr_sel == SEL_W0 || wr_sel == SEL_W1) wip_dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvp_seq.sv
// Commit sequencer: power-up load, STOP-triggered commit, optional
// zero-cross wait, and programming wait. busy is high outside the idle state.
module nvp_seq
    import nvp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic zc_pending,
    input  logic zc_en,
    input  logic commit_due,
    input  logic store_busy,
    output logic load_en,
    output logic clr_dirty,
    output logic req,
    output logic busy
);
    nvp_state_e state_q, state_d;
    logic       start;

    // Next-state and control decode
    always_comb begin
        state_d   = state_q;
        start     = 1'b0;
        load_en   = 1'b0;
        clr_dirty = 1'b0;
        case (state_q)
            ST_LOAD: begin
                load_en = 1'b1;
                state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (stop) begin
                    clr_dirty = 1'b1;
                    if (commit_due) begin
                        if (zc_en && zc_pending) begin
                            state_d = ST_WAIT_ZC;
                        end else begin
                            state_d = ST_PROG;
                            start   = 1'b1;
                        end
                    end
                end
            end
            ST_WAIT_ZC: begin
                if (!zc_pending) begin
                    state_d = ST_PROG;
                    start   = 1'b1;
                end
            end
            ST_PROG: begin
                if (!req && !store_busy) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            req     <= 1'b0;
        end else begin
            state_q <= state_d;
            req     <= start;
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/nvsettings_ctrl.sv
// Top level of the wiper/configuration persistence controller.
// Assumes stop_seen is a one-cycle pulse and that the bus interface refuses
// its address while busy is high. Strobes arriving during busy are dropped here.
module nvsettings_ctrl
    import nvp_pkg::*;
#(
    parameter int PROG_CYCLES = 50000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [5:0]         wr_data,
    input  logic               stop_seen,
    input  logic               zc_pending,
    output logic               busy,
    output logic               nv_wr_req,
    output logic [5:0]         wiper0,
    output logic [5:0]         wiper1,
    output logic [2:0]         cfg_bits
);
    logic [IMAGE_W-1:0] rd_image;
    logic [IMAGE_W-1:0] wr_image;
    logic               store_busy;
    logic               load_en;
    logic               clr_dirty;
    logic               cfg_dirty;
    logic               wip_dirty;
    logic               commit_due;
    logic               wr_ok;

    assign wr_ok      = wr_en && !busy;
    assign commit_due = cfg_dirty || (wip_dirty && !cfg_bits[CFG_VOL]);
    assign wr_image   = {5'b10000, cfg_bits, 2'b01, wiper1, 2'b00, wiper0};

    nvp_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .image     (rd_image),
        .wr_en     (wr_ok),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .clr_dirty (clr_dirty),
        .wiper0    (wiper0),
        .wiper1    (wiper1),
        .cfg       (cfg_bits),
        .cfg_dirty (cfg_dirty),
        .wip_dirty (wip_dirty)
    );

    nvp_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop       (stop_seen),
        .zc_pending (zc_pending),
        .zc_en      (cfg_bits[CFG_ZC]),
        .commit_due (commit_due),
        .store_busy (store_busy),
        .load_en    (load_en),
        .clr_dirty  (clr_dirty),
        .req        (nv_wr_req),
        .busy       (busy)
    );

    nvp_store #(
        .PROG_CYCLES (PROG_CYCLES),
        .NBYTES      (NBYTES),
        .INIT_IMAGE  (FACTORY_IMAGE)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (nv_wr_req),
        .wdata     (wr_image),
        .rdata     (rd_image),
        .prog_busy (store_busy)
    );
endmodule

// File: rtl/nvp_checker.sv
// Protocol checks on the persistence controller, attached with bind.
module nvp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       nv_wr_req,
    input logic       zc_pending,
    input logic       zc_en,
    input logic [5:0] wiper0,
    input logic [5:0] wiper1
);
    // R5: the store request lasts one cycle
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_req |=> !nv_wr_req);

    // R5: a request is always covered by busy
    a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_req |-> busy);

    // R4: with gating on, no request follows a cycle that still had a pending zero-cross
    a_r4_zc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_wr_req && zc_en) |-> !$past(zc_pending));

    // R7: wipers do not move while busy
    a_r7_wiper0_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wiper0));

    // R7: wipers do not move while busy
    a_r7_wiper1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wiper1));
endmodule

bind nvsettings_ctrl nvp_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .nv_wr_req  (nv_wr_req),
    .zc_pending (zc_pending),
    .zc_en      (cfg_bits[1]),
    .wiper0     (wiper0),
    .wiper1     (wiper1)
);

// File: tb/nvsettings_ctrl_tb.sv
// Directed bench for the persistence controller: one task per scenario.
module nvsettings_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 12;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic [5:0] wr_data = 6'd0;
    logic       stop_seen = 1'b0;
    logic       zc_pending = 1'b0;
    logic       busy;
    logic       nv_wr_req;
    logic [5:0] wiper0;
    logic [5:0] wiper1;
    logic [2:0] cfg_bits;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvsettings_ctrl #(.PROG_CYCLES(P)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .stop_seen  (stop_seen),
        .zc_pending (zc_pending),
        .busy       (busy),
        .nv_wr_req  (nv_wr_req),
        .wiper0     (wiper0),
        .wiper1     (wiper1),
        .cfg_bits   (cfg_bits)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [5:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic send_stop();
        stop_seen = 1'b1;
        tick();
        stop_seen = 1'b0;
    endtask

    // Counts the cycles busy stays high and the request pulses seen
    task automatic measure_busy(output int cycles, output int reqs);
        cycles = 0; reqs = 0;
        while (busy && cycles < 1000) begin
            if (nv_wr_req) reqs++;
            cycles++;
            tick();
        end
    endtask

    // Reset sequence with R1 checks during reset
    task automatic power_cycle();
        rst_n = 1'b0;
        tick(); tick();
        check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
        check(nv_wr_req == 1'b0, "R1 no request in reset", int'(nv_wr_req), 0);
        rst_n = 1'b1;
        tick();
        check(busy == 1'b0, "R1 busy falls after load", int'(busy), 0);
    endtask

    task automatic t_factory_powerup();
        power_cycle();
        check(cfg_bits == 3'b111, "R1 factory config", int'(cfg_bits), 7);
        check(wiper0 == 6'd33, "R2 wiper0 mute opt1", int'(wiper0), 33);
        check(wiper1 == 6'd33, "R2 wiper1 mute opt1", int'(wiper1), 33);
    endtask

    task automatic t_volatile_wiper();
        int hits = 0;
        write_reg(2'b00, 6'd5);
        send_stop();
        for (int i = 0; i < 6; i++) begin
            if (nv_wr_req || busy) hits++;
            tick();
        end
        check(hits == 0, "R3 volatile STOP no commit", hits, 0);
        check(wiper0 == 6'd5, "R3 new wiper visible", int'(wiper0), 5);
        send_stop();
        check(busy == 1'b0 && nv_wr_req == 1'b0, "R3 bare STOP", int'(busy), 0);
        power_cycle();
        check(wiper0 == 6'd33, "R3 store untouched", int'(wiper0), 33);
    endtask

    task automatic t_reserved_sel();
        int hits = 0;
        write_reg(2'b11, 6'd0);
        check(wiper0 == 6'd33 && wiper1 == 6'd33, "R8 reserved wipers", int'(wiper0), 33);
        check(cfg_bits == 3'b111, "R8 reserved config", int'(cfg_bits), 7);
        send_stop();
        for (int i = 0; i < 4; i++) begin
            if (nv_wr_req || busy) hits++;
            tick();
        end
        check(hits == 0, "R8 reserved no commit", hits, 0);
    endtask

    task automatic t_zc_gated_commit();
        int cyc, rq, early = 0;
        write_reg(2'b00, 6'd12);
        write_reg(2'b01, 6'd40);
        write_reg(2'b10, 6'b000010);
        zc_pending = 1'b1;
        send_stop();
        check(busy == 1'b1, "R4 busy during zero-cross wait", int'(busy), 1);
        for (int i = 0; i < 6; i++) begin
            if (nv_wr_req) early++;
            tick();
        end
        check(early == 0, "R4 no request while pending", early, 0);
        zc_pending = 1'b0;
        tick();
        check(nv_wr_req == 1'b1, "R4 request after zero-cross", int'(nv_wr_req), 1);
        measure_busy(cyc, rq);
        check(cyc == P + 2, "R5 busy length", cyc, P + 2);
        check(rq == 1, "R5 single request", rq, 1);
        power_cycle();
        check(cfg_bits == 3'b010, "R6 config restored", int'(cfg_bits), 2);
        check(wiper0 == 6'd12, "R10 wiper0 restored", int'(wiper0), 12);
        check(wiper1 == 6'd40, "R10 wiper1 restored", int'(wiper1), 40);
    endtask

    task automatic t_busy_ignores();
        int cyc, rq, late = 0;
        write_reg(2'b01, 6'd17);
        send_stop();
        check(nv_wr_req == 1'b1, "R9 nonvolatile wiper commit", int'(nv_wr_req), 1);
        tick();
        write_reg(2'b00, 6'd50);
        send_stop();
        measure_busy(cyc, rq);
        check(rq == 0, "R7 no extra request", rq, 0);
        check(wiper0 == 6'd12, "R7 write ignored", int'(wiper0), 12);
        for (int i = 0; i < 4; i++) begin
            if (nv_wr_req || busy) late++;
            tick();
        end
        check(late == 0, "R7 STOP ignored", late, 0);
        power_cycle();
        check(wiper1 == 6'd17, "R6 wiper1 persisted", int'(wiper1), 17);
        check(wiper0 == 6'd12, "R6 wiper0 rewritten", int'(wiper0), 12);
    endtask

    task automatic t_config_to_volatile();
        int cyc, rq;
        write_reg(2'b10, 6'b000100);
        send_stop();
        check(nv_wr_req == 1'b1, "R9 config commit in volatile", int'(nv_wr_req), 1);
        measure_busy(cyc, rq);
        check(cyc == P + 2, "R5 busy length ungated", cyc, P + 2);
        power_cycle();
        check(cfg_bits == 3'b100, "R9 config persisted", int'(cfg_bits), 4);
        check(wiper0 == 6'd63, "R2 wiper0 mute opt0", int'(wiper0), 63);
        check(wiper1 == 6'd63, "R2 wiper1 mute opt0", int'(wiper1), 63);
    endtask

    initial begin
        @(negedge clk);
        t_factory_powerup();
        t_volatile_wiper();
        t_reserved_sel();
        t_zc_gated_commit();
        t_busy_ignores();
        t_config_to_volatile();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule